// File: doc/BRIEF.md
# Real-Time Interrupt Divider

This block turns the raw oscillator clock into a slow, periodic interrupt request. Every oscillator cycle advances a binary prescaler. A selectable tap of that prescaler, between 2^10 and 2^16, drives a short modulus counter that divides again by 1 to 16. Each time the whole chain runs out, a sticky event flag is set. The interrupt line follows the flag while the enable input is high.

Software programs one 8-bit control word. It holds the tap, the modulus and an option that stops the chain while the device is in wait mode. Every write to the word restarts the chain from zero. A zero tap field turns the divider off. The flag is cleared by a write-one-to-clear strobe. If an expiry and a clear arrive in the same cycle, the expiry wins.

Top module: `rti_divider`

## Requirements
- R1: After reset the flag and the interrupt output are low and the control word is zero, so the divider is off.
- R2: The control word has the modulus field m in bits [3:0], the tap field p in bits [6:4] and the freeze-in-wait option in bit 7. A nonzero p selects a prescale of 2^(9+p), and m selects a divide of m+1.
- R3: The chain counts every oscillator cycle. With p nonzero, the flag rises exactly 2^(9+p)*(m+1) cycles after the clock edge that captures the control write, and an expiry recurs every such interval after that.
- R4: With p equal to zero the counters are held at zero and no expiry occurs, however long the clock runs.
- R5: A control write made part-way through a count restarts the chain, so the next expiry is one full interval after the new write.
- R6: A cycle with the clear strobe high and no expiry leaves the flag low after the next clock edge.
- R7: An expiry in the same cycle as a clear strobe leaves the flag set.
- R8: The interrupt output is high exactly when the flag and the enable input are both high.
- R9: With bit 7 set, every cycle in which the wait input is high is skipped by the chain and lengthens the interval by one. With bit 7 clear, the wait input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that drives the counter chain |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: modulus [3:0], tap [6:4], freeze-in-wait [7] |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| wait_mode | input | 1 | High while the device is in wait mode |
| flag | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. The prescaler holds its count while stopped, and the modulus counter never passes its limit. An off or frozen chain never expires. An expiry always leaves the flag set, even when a clear arrives with it. The exact interval lengths for several tap and modulus settings can only be shown by the bench's scenarios, which time each flag edge against the last control write. The same holds for the restart on a rewrite, the interval stretched by a wait-mode window, and the lack of effect of wait mode when the option bit is clear.

// File: rtl/rti_pkg.sv
package rti_pkg;

   // Prescale exponent selected by a nonzero tap code
   function automatic int unsigned tap_log2(input int unsigned min_log2,
                                            input int unsigned code);
      return min_log2 + code - 1;
   endfunction

   typedef enum logic [1:0] {
      CHAIN_OFF    = 2'd0,
      CHAIN_RUN    = 2'd1,
      CHAIN_FROZEN = 2'd2
   } chain_state_e;

endpackage

// File: rtl/rti_prescaler.sv
module rti_prescaler #(
   parameter int unsigned MIN_LOG2 = 10,
   parameter int unsigned TAPS     = 7,
   parameter int unsigned SEL_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned CNT_W = MIN_LOG2 + TAPS - 1;

   logic [CNT_W-1:0] cnt;
   logic [TAPS-1:0]  tap_full;

   // one all-ones detector per selectable tap
   for (genvar gi = 0; gi < TAPS; gi++) begin : g_tap
      localparam int unsigned LEN = rti_pkg::tap_log2(MIN_LOG2, gi + 1);
      assign tap_full[gi] = &cnt[LEN-1:0];
   end

   logic hit;
   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < TAPS; i++) begin
         if (int'(sel) == i + 1) hit = tap_full[i];
      end
   end

   assign tick = run && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (run)   cnt <= cnt + 1'b1;
   end

   // R9
   pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(cnt));

   // R4
   pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

endmodule

// File: rtl/rti_modulus.sv
module rti_modulus #(
   parameter int unsigned MOD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [MOD_W-1:0] limit,
   output logic             expire
);
   logic [MOD_W-1:0] cnt;

   assign expire = step && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (expire) cnt <= '0;
      else if (step)   cnt <= cnt + 1'b1;
   end

   // R3
   mod_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= limit);

endmodule

// File: rtl/rti_flag.sv
module rti_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   // R7
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);

   // R6
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);

endmodule

// File: rtl/rti_divider.sv
module rti_divider #(
   parameter int unsigned PRE_MIN_LOG2 = 10,
   parameter int unsigned PRE_TAPS     = 7,
   parameter int unsigned MOD_W        = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [7:0] ctl_wdata,
   input  logic       irq_en,
   input  logic       flag_clr,
   input  logic       wait_mode,
   output logic       flag,
   output logic       irq
);
   import rti_pkg::*;

   localparam int unsigned SEL_W  = $clog2(PRE_TAPS + 1);
   localparam int unsigned SEL_LO = MOD_W;
   localparam int unsigned FRZ_B  = MOD_W + SEL_W;
   localparam int unsigned CTL_W  = FRZ_B + 1;

   if (CTL_W != 8) begin : g_bad_ctl
      $error("control layout must fill exactly 8 bits");
   end
   if (PRE_MIN_LOG2 < 1 || PRE_TAPS < 1) begin : g_bad_pre
      $error("prescaler needs at least one tap of one bit");
   end

   logic [CTL_W-1:0] ctl;
   logic [SEL_W-1:0] sel;
   logic [MOD_W-1:0] limit;
   logic             frz_opt;
   chain_state_e     state;
   logic             run, clear, tick, expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl <= '0;
      else if (ctl_we) ctl <= ctl_wdata;
   end

   assign limit   = ctl[MOD_W-1:0];
   assign sel     = ctl[SEL_LO +: SEL_W];
   assign frz_opt = ctl[FRZ_B];

   always_comb begin
      if (sel == '0)               state = CHAIN_OFF;
      else if (frz_opt && wait_mode) state = CHAIN_FROZEN;
      else                         state = CHAIN_RUN;
   end

   assign run   = (state == CHAIN_RUN);
   assign clear = ctl_we || (state == CHAIN_OFF);

   rti_prescaler #(
      .MIN_LOG2 (PRE_MIN_LOG2),
      .TAPS     (PRE_TAPS),
      .SEL_W    (SEL_W)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .run   (run),
      .sel   (sel),
      .tick  (tick)
   );

   rti_modulus #(.MOD_W(MOD_W)) u_mod (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clear),
      .step   (tick),
      .limit  (limit),
      .expire (expire)
   );

   rti_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (expire),
      .clr   (flag_clr),
      .flag  (flag)
   );

   assign irq = flag && irq_en;

   // R4
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> !expire);

   // R9
   frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_opt && wait_mode) |-> !expire);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && flag));

endmodule

// File: tb/rti_divider_test.sv
module rti_divider_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       irq_en = 1'b0;
   logic       flag_clr = 1'b0;
   logic       wait_mode = 1'b0;
   logic       flag, irq;

   int n_chk = 0;
   int n_bad = 0;
   int since = 0;
   int rises = 0;
   int cyc = 0;
   logic flag_q = 1'b0;
   int exp_q[$];

   always #10 clk = ~clk;

   rti_divider uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_wdata (ctl_wdata),
      .irq_en    (irq_en),
      .flag_clr  (flag_clr),
      .wait_mode (wait_mode),
      .flag      (flag),
      .irq       (irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // cycles since the edge that captured the last control write
   always @(posedge clk) begin
      cyc <= cyc + 1;
      since <= ctl_we ? 0 : since + 1;
   end

   // monitor: pops the expected interval on every flag rise (R3)
   always @(negedge clk) begin
      if (rst_n && flag && !flag_q) begin
         rises++;
         if (exp_q.size() == 0) check(1'b0, "R3 unexpected flag rise", since, -1);
         else begin
            int e;
            e = exp_q.pop_front();
            check(since == e, "R3 interval", since, e);
         end
      end
      flag_q = flag;
   end

   always @(posedge clk) begin
      if (cyc > 195000) begin
         check(1'b0, "watchdog", cyc, 195000);
         summary();
      end
   end

   task automatic step;
      @(negedge clk);
      #1;
   endtask

   task automatic write_ctl(input logic [7:0] v);
      ctl_we = 1'b1;
      ctl_wdata = v;
      step();
      ctl_we = 1'b0;
   endtask

   task automatic wait_rise(input string req);
      int r0;
      int n;
      r0 = rises;
      n = 0;
      while (rises == r0 && n < 70000) begin
         step();
         n++;
      end
      check(rises != r0, req, rises - r0, 1);
   endtask

   task automatic clear_flag;
      flag_clr = 1'b1;
      step();
      flag_clr = 1'b0;
      check(flag == 1'b0, "R6 flag cleared", int'(flag), 0);
   endtask

   task automatic wait_until(input int target);
      while (since < target) step();
   endtask

   initial begin
      step();
      // R1
      check(flag == 1'b0, "R1 flag at reset", int'(flag), 0);
      check(irq == 1'b0, "R1 irq at reset", int'(irq), 0);
      rst_n = 1'b1;
      repeat (2000) step();
      check(rises == 0, "R1 R4 off after reset", rises, 0);

      // R2 R3: p=1, m=0 -> 1024, twice
      write_ctl(8'h10);
      exp_q.push_back(1024);
      wait_rise("R3 first expiry p1m0");
      clear_flag();
      exp_q.push_back(2048);
      wait_rise("R3 recurring expiry p1m0");
      clear_flag();

      // R2: p=1, m=3 -> 4096
      write_ctl(8'h13);
      exp_q.push_back(4096);
      wait_rise("R2 p1m3");
      // R8
      irq_en = 1'b1;
      #1;
      check(irq == 1'b1, "R8 irq with enable", int'(irq), 1);
      irq_en = 1'b0;
      #1;
      check(irq == 1'b0, "R8 irq masked", int'(irq), 0);
      clear_flag();

      // R2: p=2, m=0 -> 2048
      write_ctl(8'h20);
      exp_q.push_back(2048);
      wait_rise("R2 p2m0");
      clear_flag();

      // R2: p=1, m=15 -> 16384
      write_ctl(8'h1F);
      exp_q.push_back(16384);
      wait_rise("R2 p1m15");
      clear_flag();

      // R2: p=7, m=0 -> 65536
      write_ctl(8'h70);
      exp_q.push_back(65536);
      wait_rise("R2 p7m0");
      clear_flag();

      // R4: off
      write_ctl(8'h05);
      begin
         int r0;
         r0 = rises;
         repeat (3000) step();
         check(rises == r0 && flag == 1'b0, "R4 off no expiry", rises - r0, 0);
      end

      // R5: restart part-way
      write_ctl(8'h10);
      wait_until(500);
      write_ctl(8'h10);
      exp_q.push_back(1024);
      wait_rise("R5 restart");
      // R7: clear coincident with the next expiry at 2048
      wait_until(2047);
      flag_clr = 1'b1;
      step();
      flag_clr = 1'b0;
      check(flag == 1'b1, "R7 expiry beats clear", int'(flag), 1);
      check(since == 2048, "R7 timing", since, 2048);
      clear_flag();

      // R9: freeze option with a 100-cycle wait window
      write_ctl(8'h90);
      exp_q.push_back(1124);
      wait_until(200);
      wait_mode = 1'b1;
      repeat (100) step();
      wait_mode = 1'b0;
      wait_rise("R9 frozen window");
      clear_flag();

      // R9: wait input ignored without the option
      write_ctl(8'h10);
      exp_q.push_back(1024);
      wait_until(200);
      wait_mode = 1'b1;
      repeat (100) step();
      wait_mode = 1'b0;
      wait_rise("R9 wait ignored");
      clear_flag();

      check(exp_q.size() == 0, "R3 all expiries seen", exp_q.size(), 0);
      summary();
   end

endmodule